// File: doc/BRIEF.md
# Posted Write Buffer Retire Controller

This block sits between a memory device's column-command decoder and its row-buffer storage. A write addressed to this device is not applied to the row buffer in its own slot. The block instead parks the 128-bit dualoct, its 16-bit byte mask and its bank and column address in a single-entry buffer. The entry is written to the row buffer during a later column-command slot. Posting writes this way lets the internal data path skip the bus turnaround that a read right after a write would otherwise need.

Each cycle carries at most one decoded column command. The command names the device it targets, and the block compares that 5-bit target with its own ID pin. The retire decision depends on the kind of command and on who it targets:

- A read, write or no-op aimed at another device frees the slot for a retire.
- A write or no-op aimed at this device also frees the slot.
- A read aimed at this device keeps the entry parked. If that read hits the parked bank and column, the parked bytes are merged over the data read from the array.

The command input is a valid-only stream with no back-pressure: each valid slot is consumed in the cycle it is presented. The retire output is a one-cycle strobe, and the storage must accept it. Status and ID pins are plain levels.

Top module: `wrbuf_retire`

## Requirements
- R1: A valid write (cmd_op = 1) whose cmd_dev equals own_id stores cmd_wdata, cmd_wmask, cmd_bank and cmd_col, and buf_full is 1 from the cycle after that slot.
- R2: A write captured into an empty buffer produces no retire strobe. The data reaches ret_valid only through a later slot.
- R3: With the buffer full, a valid slot of any opcode whose cmd_dev differs from own_id retires the entry. ret_valid is 1 in the next cycle, carrying the parked bank, column and data, and buf_full drops.
- R4: With the buffer full, a valid write or no-op (cmd_op = 0) to own_id retires the entry in the same way.
- R5: A valid read (cmd_op = 2) to own_id never retires. ret_valid stays 0 in the next cycle and the parked entry, including buf_full, is unchanged.
- R6: ret_byte_en bit b is the inverse of bit b of the parked mask. A mask of zero enables all 16 bytes, and mask bit b = 1 suppresses byte b (bits [8b+7:8b] of the data).
- R7: The device match compares all 5 ID bits, so a target that differs in any single bit counts as another device. Opcode 3 behaves as a no-op.
- R8: A write to own_id that arrives while the buffer is full retires the old entry in that slot and captures the new one in the same cycle. buf_full stays 1.
- R9: During a valid read to own_id with the buffer full and cmd_bank/cmd_col equal to the parked address, rd_hit is 1 in the same cycle. rd_data byte b then takes the parked byte where mask bit b is 0 and arr_rdata elsewhere. In every other case rd_hit is 0 and rd_data equals arr_rdata.
- R10: Synchronous reset empties the buffer and issues no retire. A cycle with cmd_valid = 0 changes nothing and issues no retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_id | input | 5 | This device's ID |
| cmd_valid | input | 1 | A column command is present this slot |
| cmd_op | input | 2 | 0 no-op, 1 write, 2 read, 3 treated as no-op |
| cmd_dev | input | 5 | Target device of the command |
| cmd_bank | input | 5 | Bank address of the command |
| cmd_col | input | 6 | Dualoct (column) address of the command |
| cmd_wdata | input | 128 | Write dualoct, byte b in bits [8b+7:8b] |
| cmd_wmask | input | 16 | Write byte mask, 1 suppresses that byte |
| arr_rdata | input | 128 | Array read data for the current read |
| rd_data | output | 128 | Read data with parked bytes merged in |
| rd_hit | output | 1 | Current read hits the parked entry |
| ret_valid | output | 1 | Retire strobe into the row buffer |
| ret_bank | output | 5 | Retire bank |
| ret_col | output | 6 | Retire dualoct address |
| ret_data | output | 128 | Retire data |
| ret_byte_en | output | 16 | Retire byte enables |
| buf_full | output | 1 | Buffer holds an entry |

## Verification
The bench sweeps every opcode, including the spare code. Each opcode is tried with idle and valid slots, with an empty and a pre-filled buffer, and with a target equal to own_id or differing in each single ID bit. This separates the read-to-self hold from all retiring cases, and it separates overwrite-with-retire from a plain capture. Reads to own_id are tried at both the parked address and a different one, so a forwarding error is told apart from a retire error. The parked masks rotate through zero, all-ones, half and single-byte patterns, which exposes byte-lane order mistakes.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
  typedef enum logic [1:0] {
    COP_NOP   = 2'd0,
    COP_WRITE = 2'd1,
    COP_READ  = 2'd2,
    COP_SPARE = 2'd3
  } col_op_e;
endpackage

// File: rtl/wrbuf_slot_ctl.sv
module wrbuf_slot_ctl #(
  parameter int DEV_W = 5
) (
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [DEV_W-1:0] cmd_dev,
  input  logic [DEV_W-1:0] own_id,
  input  logic             full,
  output logic             do_capture,
  output logic             do_retire,
  output logic             rd_self
);
  import wrbuf_pkg::*;

  logic    is_self;
  col_op_e op;

  always_comb begin
    op         = col_op_e'(cmd_op);
    is_self    = (cmd_dev == own_id);
    rd_self    = cmd_valid && is_self && (op == COP_READ);
    do_capture = cmd_valid && is_self && (op == COP_WRITE);
    // any valid slot except a read to this device may drain the entry
    do_retire  = full && cmd_valid && !rd_self;
  end
endmodule

// File: rtl/wrbuf_entry.sv
module wrbuf_entry #(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int NBYTES = 16,
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              drain,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NBYTES-1:0] in_mask,
  output logic              full,
  output logic [BANK_W-1:0] q_bank,
  output logic [COL_W-1:0]  q_col,
  output logic [DATA_W-1:0] q_data,
  output logic [NBYTES-1:0] q_mask
);
  always_ff @(posedge clk) begin
    if (rst)        full <= 1'b0;
    else if (load)  full <= 1'b1;
    else if (drain) full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_bank <= in_bank;
      q_col  <= in_col;
      q_data <= in_data;
      q_mask <= in_mask;
    end
  end
endmodule

// File: rtl/wrbuf_fwd_merge.sv
module wrbuf_fwd_merge #(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int NBYTES = 16,
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              rd_self,
  input  logic              full,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [BANK_W-1:0] e_bank,
  input  logic [COL_W-1:0]  e_col,
  input  logic [DATA_W-1:0] e_data,
  input  logic [NBYTES-1:0] e_mask,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              hit,
  output logic [DATA_W-1:0] merged
);
  assign hit = rd_self && full && (rd_bank == e_bank) && (rd_col == e_col);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = (hit && !e_mask[b]) ? e_data[b*8 +: 8]
                                                  : arr_rdata[b*8 +: 8];
  end
endmodule

// File: rtl/wrbuf_retire.sv
module wrbuf_retire #(
  parameter int DEV_W  = 5,
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int NBYTES = 16,
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  own_id,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [NBYTES-1:0] cmd_wmask,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              ret_valid,
  output logic [BANK_W-1:0] ret_bank,
  output logic [COL_W-1:0]  ret_col,
  output logic [DATA_W-1:0] ret_data,
  output logic [NBYTES-1:0] ret_byte_en,
  output logic              buf_full
);
  logic              do_capture, do_retire, rd_self;
  logic [BANK_W-1:0] e_bank;
  logic [COL_W-1:0]  e_col;
  logic [DATA_W-1:0] e_data;
  logic [NBYTES-1:0] e_mask;

  wrbuf_slot_ctl #(.DEV_W(DEV_W)) u_ctl (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_dev   (cmd_dev),
    .own_id    (own_id),
    .full      (buf_full),
    .do_capture(do_capture),
    .do_retire (do_retire),
    .rd_self   (rd_self)
  );

  wrbuf_entry #(.BANK_W(BANK_W), .COL_W(COL_W), .NBYTES(NBYTES)) u_entry (
    .clk    (clk),
    .rst    (rst),
    .load   (do_capture),
    .drain  (do_retire),
    .in_bank(cmd_bank),
    .in_col (cmd_col),
    .in_data(cmd_wdata),
    .in_mask(cmd_wmask),
    .full   (buf_full),
    .q_bank (e_bank),
    .q_col  (e_col),
    .q_data (e_data),
    .q_mask (e_mask)
  );

  wrbuf_fwd_merge #(.BANK_W(BANK_W), .COL_W(COL_W), .NBYTES(NBYTES)) u_fwd (
    .rd_self  (rd_self),
    .full     (buf_full),
    .rd_bank  (cmd_bank),
    .rd_col   (cmd_col),
    .e_bank   (e_bank),
    .e_col    (e_col),
    .e_data   (e_data),
    .e_mask   (e_mask),
    .arr_rdata(arr_rdata),
    .hit      (rd_hit),
    .merged   (rd_data)
  );

  // retire port: registered copy of the entry taken before any overwrite
  always_ff @(posedge clk) begin
    if (rst) ret_valid <= 1'b0;
    else     ret_valid <= do_retire;
  end

  always_ff @(posedge clk) begin
    if (do_retire) begin
      ret_bank    <= e_bank;
      ret_col     <= e_col;
      ret_data    <= e_data;
      ret_byte_en <= ~e_mask;
    end
  end
endmodule

// File: rtl/wrbuf_retire_chk.sv
module wrbuf_retire_chk #(
  parameter int DEV_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [DEV_W-1:0] own_id,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [DEV_W-1:0] cmd_dev,
  input logic             ret_valid,
  input logic             buf_full
);
  assert_capture_fills_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && cmd_dev == own_id) |=> buf_full);

  assert_retire_needs_entry_R2: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(buf_full));

  assert_other_dev_retires_R3: assert property (@(posedge clk) disable iff (rst)
    (buf_full && cmd_valid && cmd_dev != own_id) |=> ret_valid);

  assert_own_wr_nop_retires_R4: assert property (@(posedge clk) disable iff (rst)
    (buf_full && cmd_valid && cmd_dev == own_id && cmd_op != 2'd2) |=> ret_valid);

  assert_own_read_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (buf_full && cmd_valid && cmd_dev == own_id && cmd_op == 2'd2)
      |=> (!ret_valid && buf_full));

  assert_idle_no_retire_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !ret_valid);

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!buf_full && !ret_valid));
endmodule

bind wrbuf_retire wrbuf_retire_chk #(.DEV_W(DEV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .own_id   (own_id),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .cmd_dev  (cmd_dev),
  .ret_valid(ret_valid),
  .buf_full (buf_full)
);

// File: tb/wrbuf_retire_tb.sv
module wrbuf_retire_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    own_id;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [4:0]    cmd_dev;
  logic [4:0]    cmd_bank;
  logic [5:0]    cmd_col;
  logic [DW-1:0] cmd_wdata;
  logic [NB-1:0] cmd_wmask;
  logic [DW-1:0] arr_rdata;
  logic [DW-1:0] rd_data;
  logic          rd_hit;
  logic          ret_valid;
  logic [4:0]    ret_bank;
  logic [5:0]    ret_col;
  logic [DW-1:0] ret_data;
  logic [NB-1:0] ret_byte_en;
  logic          buf_full;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the buffer
  bit            m_full;
  logic [4:0]    m_bank;
  logic [5:0]    m_col;
  logic [DW-1:0] m_data;
  logic [NB-1:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrbuf_retire u_dut (
    .clk(clk), .rst(rst), .own_id(own_id),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
    .cmd_wmask(cmd_wmask), .arr_rdata(arr_rdata), .rd_data(rd_data),
    .rd_hit(rd_hit), .ret_valid(ret_valid), .ret_bank(ret_bank),
    .ret_col(ret_col), .ret_data(ret_data), .ret_byte_en(ret_byte_en),
    .buf_full(buf_full)
  );

  function automatic logic [DW-1:0] pattern(input int seed);
    logic [DW-1:0] v;
    for (int b = 0; b < NB; b++) v[b*8 +: 8] = 8'(seed * 37 + b * 29 + 5);
    return v;
  endfunction

  function automatic logic [NB-1:0] mask_pick(input int i);
    case (i % 4)
      0:       return '0;
      1:       return '1;
      2:       return 16'h00FF;
      default: return NB'(1) << (i % NB);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0;
    @(posedge clk); #1;
    m_full = 0;
    check(buf_full == 1'b0, "R10 full after reset", DW'(buf_full), '0);
    check(ret_valid == 1'b0, "R10 no retire on reset", DW'(ret_valid), '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic slot(input bit v, input logic [1:0] op, input logic [4:0] dev,
                      input logic [4:0] bank, input logic [5:0] col,
                      input logic [DW-1:0] wd, input logic [NB-1:0] wm,
                      input logic [DW-1:0] ar);
    bit self, rdself, cap, exp_ret, exp_hit;
    logic [DW-1:0] exp_rd;
    string tag;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_dev = dev; cmd_bank = bank; cmd_col = col;
    cmd_wdata = wd; cmd_wmask = wm; arr_rdata = ar;
    self    = (dev == own_id);
    rdself  = v && self && (op == 2'd2);
    cap     = v && self && (op == 2'd1);
    exp_ret = m_full && v && !rdself;
    exp_hit = rdself && m_full && bank == m_bank && col == m_col;
    for (int b = 0; b < NB; b++)
      exp_rd[b*8 +: 8] = (exp_hit && !m_mask[b]) ? m_data[b*8 +: 8] : ar[b*8 +: 8];
    #1;
    check(rd_hit == exp_hit, "R9 rd_hit", DW'(rd_hit), DW'(exp_hit));
    check(rd_data == exp_rd, "R9 rd_data", rd_data, exp_rd);
    if (!v)                  tag = "R10 idle slot";
    else if (!m_full && cap) tag = "R2 capture no retire";
    else if (m_full && cap)  tag = "R8 overwrite retire";
    else if (rdself)         tag = "R5 own read hold";
    else if (self)           tag = "R4 own wr/nop retire";
    else                     tag = "R3 other dev retire (R7 id)";
    @(posedge clk); #1;
    check(ret_valid == exp_ret, tag, DW'(ret_valid), DW'(exp_ret));
    if (exp_ret) begin
      check(ret_data == m_data, "R3 retire data", ret_data, m_data);
      check({ret_bank, ret_col} == {m_bank, m_col}, "R3 retire addr",
            DW'({ret_bank, ret_col}), DW'({m_bank, m_col}));
      check(ret_byte_en == ~m_mask, "R6 byte enables", DW'(ret_byte_en), DW'(~m_mask));
    end
    m_full = cap || (m_full && !exp_ret);
    if (cap) begin m_bank = bank; m_col = col; m_data = wd; m_mask = wm; end
    check(buf_full == m_full, "R1 buf_full", DW'(buf_full), DW'(m_full));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    logic [4:0] dev, pbank, rbank;
    logic [5:0] pcol, rcol;
    rst = 1'b1; own_id = 5'h13; cmd_valid = 0; cmd_op = 0; cmd_dev = 0;
    cmd_bank = 0; cmd_col = 0; cmd_wdata = 0; cmd_wmask = 0; arr_rdata = 0;
    m_full = 0; m_bank = 0; m_col = 0; m_data = 0; m_mask = 0;
    repeat (2) @(posedge clk);
    idx = 0;
    for (int pre = 0; pre < 2; pre++)
      for (int op = 0; op < 4; op++)
        for (int ds = 0; ds < 2; ds++)
          for (int v = 0; v < 2; v++)
            for (int ha = 0; ha < 2; ha++) begin
              idx++;
              do_reset();
              pbank = 5'(idx * 3);
              pcol  = 6'(idx * 7 + 1);
              if (pre == 1)
                slot(1, 2'd1, own_id, pbank, pcol, pattern(idx), mask_pick(idx), pattern(500));
              dev   = (ds == 0) ? own_id : (own_id ^ (5'd1 << (idx % 5)));
              rbank = (ha == 1) ? pbank : pbank ^ 5'd1;
              rcol  = (ha == 1) ? pcol  : pcol ^ 6'(1 << (idx % 6));
              slot(v[0], 2'(op), dev, rbank, rcol, pattern(idx + 100),
                   mask_pick(idx + 1), pattern(idx + 200));
              // drain whatever remains through a no-op to self
              slot(1, 2'd0, own_id, 0, 0, '0, '0, '0);
            end
    // back-to-back writes, then held by reads, then drained by another device
    do_reset();
    for (int k = 0; k < 6; k++)
      slot(1, 2'd1, own_id, 5'(k), 6'(k * 9), pattern(k + 300), mask_pick(k), '0);
    for (int k = 0; k < 4; k++)
      slot(1, 2'd2, own_id, 5'(5), 6'(45), '0, '0, pattern(k + 400));
    slot(1, 2'd2, own_id ^ 5'h10, 0, 0, '0, '0, '0);
    slot(0, 2'd1, own_id, 0, 0, '0, '0, '0);
    // reset while full: no retire escapes
    slot(1, 2'd1, own_id, 5'd2, 6'd3, pattern(600), '0, '0);
    do_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule